// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a short burst to a memory. When the load strobe is asserted it captures a full external address. The bits above the burst window keep that value for the whole burst. The low bits, whose width follows from the burst length, are recomputed from the captured start offset and a beat counter. The beat counter steps on each cycle in which the advance input is high.

Two visit orders are available. The linear order adds the beat number to the start offset and wraps within the burst window. The interleaved order XORs the start offset with the beat number. The order input is sampled together with the address on a load. A high level, which is also the reset default, selects the interleaved order. The outputs come straight from registers through a small mapping network: the current full address and the beat index. Neither needs a handshake, so every pin is a plain control or data pin.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, before the first load, `addr_o` is zero and `beat_o` is zero.
- R2: On a clock edge with `load_i` high, the next cycle shows `addr_o` equal to the `addr_i` value sampled at that edge and `beat_o` equal to 0.
- R3: Bits of `addr_o` above the burst window (bit index BEAT_W and up) change only on a clock edge with `load_i` high.
- R4: With the linear order (order sampled as 0), the low BEAT_W bits of `addr_o` equal (start + beat) modulo BURST_LEN, where start is the low BEAT_W bits of the loaded address.
- R5: With the interleaved order (order sampled as 1), the low BEAT_W bits of `addr_o` equal start XOR beat.
- R6: `order_i` is sampled only on a load edge. Changing it during a burst leaves `addr_o` unchanged.
- R7: On an edge with `load_i` low and `advance_i` low, `addr_o` and `beat_o` hold their values (burst suspend).
- R8: After the last beat (beat BURST_LEN-1), one more advance returns `beat_o` to 0 and `addr_o` to the start address, and the sequence repeats.
- R9: When `load_i` and `advance_i` are both high on the same edge, the load wins. The new address shows at beat 0, whatever the state of the burst.
- R10: On an edge with `load_i` low and `advance_i` high, `beat_o` increments by one modulo BURST_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| load_i | input | 1 | Capture `addr_i` and `order_i`, restart at beat 0 |
| advance_i | input | 1 | Step to the next beat |
| order_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W | Burst start address |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | BEAT_W | Index of the current beat since the last load |

## Verification
The bench builds the block with its defaults: a 17-bit address and a four-beat burst. With these values each of the four start offsets can be loaded in both orders. The upper address bits can carry distinctive patterns, so a disturbed upper field shows up at once. Bursts run for more than four advances, with suspend cycles inside them. This covers wrap-around, hold and the mid-burst order change. Loads that coincide with an advance are also applied in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] cnt_o
);
  logic [BEAT_W-1:0] cnt_q;

  // clear has priority over step; the count wraps naturally at 2**BEAT_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_o == '0));
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] off_o
);
  logic [BEAT_W-1:0] lin_off;
  logic [BEAT_W-1:0] ilv_off;

  assign lin_off = start_i + beat_i;  // wraps modulo 2**BEAT_W
  assign ilv_off = start_i ^ beat_i;

  always_comb begin
    off_o = (order_i == ORDER_INTERLEAVE) ? ilv_off : lin_off;
  end

  // beat zero must always land on the captured start offset (R2)
  always_comb begin
    if (beat_i == '0) assert_beat0_is_start_R2: assert (off_o == start_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low_off;

  // address and order are captured together, once per burst
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORDER_INTERLEAVE;
    end else if (load_i) begin
      base_q  <= addr_i;
      order_q <= burst_order_e'(order_i);
    end
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load_i),
    .step_i  (advance_i),
    .cnt_o   (beat)
  );

  burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order_q),
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat),
    .off_o   (low_off)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_off};
  assign beat_o = beat;

  assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(addr_i)) && (beat_o == '0));

  assert_upper_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_i) |=> ($stable(addr_o) && $stable(beat_o)));

  assert_order_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_i && (order_i != $past(order_i))) |=> $stable(addr_o));

  assert_beat_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && advance_i) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1)));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 17;
  localparam int BURST_LEN  = 4;
  localparam int BEAT_W     = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_i = 1'b0;
  logic              advance_i = 1'b0;
  logic              order_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [BEAT_W-1:0] beat_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_base = 0;
  int m_beat = 0;
  int m_ilv  = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic int exp_addr();
    int start = m_base % BURST_LEN;
    int low   = m_ilv ? (start ^ m_beat) : ((start + m_beat) % BURST_LEN);
    return m_base - start + low;
  endfunction

  task automatic compare(string tag);
    int ea = exp_addr();
    checks++;
    if (int'(addr_o) != ea || int'(beat_o) != m_beat) begin
      errors++;
      $display("FAIL %s: addr=%0h beat=%0d expected addr=%0h beat=%0d",
               tag, addr_o, beat_o, ea, m_beat);
    end
  endtask

  // drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge
  task automatic step(bit ld, bit adv, bit ord, int a, string tag);
    load_i = ld; advance_i = adv; order_i = ord; addr_i = ADDR_W'(a);
    @(posedge clk);
    if (ld) begin
      m_base = a; m_beat = 0; m_ilv = ord;
    end else if (adv) begin
      m_beat = (m_beat + 1) % BURST_LEN;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    step(0, 0, 1, 0, "R1 after reset");
    step(0, 1, 0, 0, "R10 advance before load");

    for (int md = 0; md < 2; md++) begin
      for (int st = 0; st < BURST_LEN; st++) begin
        int base = 17'h1A5A4 + st + (md << 8);
        string tg = md ? "R5" : "R4";
        step(1, 0, md[0], base, "R2 load");
        step(0, 1, md[0], 0, tg);
        step(0, 0, md[0], 0, "R7 suspend");
        step(0, 0, md[0], 0, "R7 suspend");
        step(0, 1, md[0], 0, tg);
        step(0, 1, md[0], 0, tg);
        step(0, 1, md[0], 0, "R8 wrap");
        step(0, 1, md[0], 0, "R8 repeat");
        step(0, 0, !md[0], 0, "R6 order change ignored");
        step(0, 1, !md[0], 0, "R6 order kept");
        step(0, 1, md[0], 0, "R3 upper held");
      end
    end

    step(1, 0, 0, 17'h0F0F3, "R2 load linear");
    step(0, 1, 0, 0, "R4");
    step(1, 1, 1, 17'h12342, "R9 load beats advance");
    step(0, 1, 1, 0, "R5");
    step(0, 1, 1, 0, "R5");
    step(1, 1, 0, 17'h1FFFF, "R9 mid-burst reload");
    step(0, 1, 0, 0, "R4 from 3");
    step(0, 0, 0, 0, "R7 hold");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule